// File: doc/BRIEF.md
# Constant Off-Time Current Limiter

This block watches the load current of one bridge, sampled as an unsigned milliamp code, together with a junction temperature code in whole degrees Celsius. When the current reaches a limit that depends on temperature, it asks the bridge to switch off for a fixed number of clock cycles. It then releases the request so the bridge can switch on again. The result is a constant off-time chopping loop.

The limit stays at a nominal value up to a knee temperature. Above the knee it falls linearly, and it reaches a floor value at the shutdown temperature. At or above the shutdown temperature the block reports an overtemperature fault and does not start any off-time. That fault clears only once the temperature has dropped by a hysteresis margin.

Separately, a hard-short detector compares the current with one of two thresholds. The high-side threshold or the low-side threshold is chosen by a side select input. A short produces a single-cycle fault pulse. An output-transition strobe starts a blanking window, and inside that window short detection is masked. All durations are parameters given in nanoseconds and converted to cycles from the clock frequency. The defaults are 100 MHz, a 20 µs off-time (2000 cycles) and a 16.5 µs blanking time (1650 cycles).

Top module: `cur_limiter`

## Requirements
- R1: While rst_ni is low, and after its release while no input is active, force_off_o, short_o and ot_fault_o are all 0.
- R2: At temperatures up to 160 °C the limit is 6500 mA. A sample with cur_ma_i >= limit starts an off-time, and a sample of limit-1 does not.
- R3: For temperatures from 161 to 174 °C the limit is 6500 - ((T-160)*4000)/15, using integer division that truncates. This gives 4634 mA at 167 °C and 2767 mA at 174 °C.
- R4: force_off_o rises in the cycle after the sample that reaches the limit. It stays high for exactly OFF_CYC cycles (2000 by default) and then goes low for at least one cycle.
- R5: Limit samples that arrive while force_off_o is high neither restart the off-time nor extend it. With the current held at the limit, force_off_o is low for exactly one cycle between off-times.
- R6: A sample with temp_c_i >= 175 sets ot_fault_o in the next cycle. No off-time starts from that sample, nor from any sample taken while ot_fault_o is high.
- R7: Once set, ot_fault_o stays high while temp_c_i > 165. It clears in the cycle after a sample with temp_c_i <= 165.
- R8: Outside blanking, short_o pulses high for one cycle in the cycle after the first sample with cur_ma_i >= 11000 when hs_sel_i=1, or with cur_ma_i >= 8000 when hs_sel_i=0. A continued short gives no further pulse until the condition has gone away.
- R9: A cycle with edge_i=1 masks short detection for BLANK_CYC cycles (1650 by default), counting the strobe cycle itself. With a short present throughout, short_o is first high at the (BLANK_CYC+1)-th sampled cycle after the strobe. A new strobe restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_ma_i | input | CUR_W (14) | Load current sample, unsigned mA |
| hs_sel_i | input | 1 | 1: sample is high-side current, 0: low-side |
| temp_c_i | input | TEMP_W (8) | Junction temperature, unsigned °C |
| edge_i | input | 1 | Output transition strobe, one cycle per transition |
| force_off_o | output | 1 | Bridge force-off request (off-time active) |
| short_o | output | 1 | Hard-short fault pulse |
| ot_fault_o | output | 1 | Overtemperature fault level |

## Verification
The bench sweeps the temperature from 150 to 174 °C. At each step it applies the computed limit minus one and then the limit itself. This tells a correct fold-back slope and a correct knee position from off-by-one compare errors and from truncation errors in the division. Every off-time that gets triggered is measured to the exact cycle. A held overcurrent then shows the difference between ignoring new limit samples and restarting the timer on them. The short detector is driven just below and just at both side thresholds, and again with a permanent short after one strobe and after two. These patterns separate the side select, the single-pulse behaviour and the length and restart of the blanking window. A temperature walk through 175, 170, 166 and 165 °C checks fault set, hysteresis hold and clear, and confirms that limiting is blocked while the fault is active.

// File: rtl/cl_pkg.sv
package cl_pkg;
  // Linear fold-back between knee and shutdown temperature, integer mA.
  function automatic int fold_limit(input int t, input int knee_c, input int stop_c,
                                    input int nom_ma, input int floor_ma);
    if (t <= knee_c) return nom_ma;
    if (t >= stop_c) return floor_ma;
    return nom_ma - ((t - knee_c) * (nom_ma - floor_ma)) / (stop_c - knee_c);
  endfunction

  function automatic int ns_to_cyc(input longint clk_hz, input longint ns);
    return int'((clk_hz * ns) / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/cl_temp_guard.sv
module cl_temp_guard #(
  parameter int TEMP_W   = 8,
  parameter int CUR_W    = 14,
  parameter int KNEE_C   = 160,
  parameter int STOP_C   = 175,
  parameter int HYS_C    = 10,
  parameter int NOM_MA   = 6500,
  parameter int FLOOR_MA = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [CUR_W-1:0]  thr_o,
  output logic              ot_hit_o,
  output logic              ot_o
);
  localparam int CLR_C = STOP_C - HYS_C;

  int t_c;
  int lim_ma;

  always_comb begin
    t_c      = int'(temp_i);
    lim_ma   = cl_pkg::fold_limit(t_c, KNEE_C, STOP_C, NOM_MA, FLOOR_MA);
    thr_o    = CUR_W'(lim_ma);
    ot_hit_o = (t_c >= STOP_C);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ot_o <= 1'b0;
    else if (ot_hit_o)    ot_o <= 1'b1;
    else if (t_c <= CLR_C) ot_o <= 1'b0;
  end

  always_comb begin
    if (rst_ni) begin
      p_thr_span_r3: assert (int'(thr_o) >= FLOOR_MA && int'(thr_o) <= NOM_MA);
    end
  end

  p_ot_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_hit_o |=> ot_o);

  p_ot_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_o && int'(temp_i) > CLR_C) |=> ot_o);
endmodule

// File: rtl/cl_off_timer.sv
module cl_off_timer #(
  parameter int CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (active_o)     cnt_q <= cnt_q - CW'(1);
    else if (start_i)      cnt_q <= CW'(CYC);
  end

  // A request on the last active cycle must not extend the window.
  p_no_extend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cnt_q == CW'(1)) |=> !active_o);

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active_o) |=> active_o);
endmodule

// File: rtl/cl_short_guard.sv
module cl_short_guard #(
  parameter int CUR_W     = 14,
  parameter int HS_MA     = 11000,
  parameter int LS_MA     = 8000,
  parameter int BLANK_CYC = 1650
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] cur_i,
  input  logic             hs_sel_i,
  input  logic             edge_i,
  output logic             short_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] blank_q;
  logic          blanked;
  logic          over;
  logic          qual;
  logic          qual_q;

  assign blanked = edge_i || (blank_q != '0);
  assign over    = hs_sel_i ? (cur_i >= CUR_W'(HS_MA)) : (cur_i >= CUR_W'(LS_MA));
  assign qual    = over && !blanked;

  // Window counts the strobe cycle plus BLANK_CYC-1 following cycles.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            blank_q <= '0;
    else if (edge_i)        blank_q <= BW'(BLANK_CYC - 1);
    else if (blank_q != '0) blank_q <= blank_q - BW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      qual_q  <= qual;
      short_o <= qual && !qual_q;
    end
  end

  p_blank_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !short_o);

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |=> !short_o);
endmodule

// File: rtl/cur_limiter.sv
module cur_limiter #(
  parameter longint CLK_HZ   = 100_000_000,
  parameter int     OFF_NS   = 20000,
  parameter int     BLANK_NS = 16500,
  parameter int     CUR_W    = 14,
  parameter int     TEMP_W   = 8,
  parameter int     KNEE_C   = 160,
  parameter int     STOP_C   = 175,
  parameter int     HYS_C    = 10,
  parameter int     NOM_MA   = 6500,
  parameter int     FLOOR_MA = 2500,
  parameter int     HS_MA    = 11000,
  parameter int     LS_MA    = 8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CUR_W-1:0]  cur_ma_i,
  input  logic              hs_sel_i,
  input  logic [TEMP_W-1:0] temp_c_i,
  input  logic              edge_i,
  output logic              force_off_o,
  output logic              short_o,
  output logic              ot_fault_o
);
  localparam int OFF_CYC   = cl_pkg::ns_to_cyc(CLK_HZ, longint'(OFF_NS));
  localparam int BLANK_CYC = cl_pkg::ns_to_cyc(CLK_HZ, longint'(BLANK_NS));

  logic [CUR_W-1:0] thr;
  logic             ot_hit;
  logic             lim_hit;

  cl_temp_guard #(
    .TEMP_W(TEMP_W), .CUR_W(CUR_W), .KNEE_C(KNEE_C), .STOP_C(STOP_C),
    .HYS_C(HYS_C), .NOM_MA(NOM_MA), .FLOOR_MA(FLOOR_MA)
  ) u_temp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .temp_i  (temp_c_i),
    .thr_o   (thr),
    .ot_hit_o(ot_hit),
    .ot_o    (ot_fault_o)
  );

  assign lim_hit = (cur_ma_i >= thr) && !ot_hit && !ot_fault_o;

  cl_off_timer #(.CYC(OFF_CYC)) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lim_hit),
    .active_o(force_off_o)
  );

  cl_short_guard #(
    .CUR_W(CUR_W), .HS_MA(HS_MA), .LS_MA(LS_MA), .BLANK_CYC(BLANK_CYC)
  ) u_short (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cur_i   (cur_ma_i),
    .hs_sel_i(hs_sel_i),
    .edge_i  (edge_i),
    .short_o (short_o)
  );

  p_limit_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_hit && !force_off_o) |=> force_off_o);

  p_ot_no_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_hit || ot_fault_o) |=> !$rose(force_off_o));
endmodule

// File: tb/sim_cur_limiter.sv
module sim_cur_limiter;
  localparam int OFF_CYC   = 2000;
  localparam int BLANK_CYC = 1650;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] cur;
  logic        hs_sel;
  logic [7:0]  temp;
  logic        edge_s;
  logic        force_off;
  logic        short_p;
  logic        ot_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cur_limiter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cur_ma_i   (cur),
    .hs_sel_i   (hs_sel),
    .temp_c_i   (temp),
    .edge_i     (edge_s),
    .force_off_o(force_off),
    .short_o    (short_p),
    .ot_fault_o (ot_fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_thr(input int t);
    if (t <= 160) return 6500;
    return 6500 - ((t - 160) * 4000) / 15;
  endfunction

  task automatic count_high(output int n);
    n = 0;
    while (force_off === 1'b1 && n < 5000) begin
      n++;
      step();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    int i;
    int seen;
    rst_n = 1'b0; cur = '0; hs_sel = 1'b0; temp = 8'd25; edge_s = 1'b0;
    repeat (3) step();
    chk("R1 force in reset", int'(force_off), 0);
    chk("R1 short in reset", int'(short_p), 0);
    chk("R1 ot in reset", int'(ot_fault), 0);
    rst_n = 1'b1;
    step();
    chk("R1 force after reset", int'(force_off), 0);
    chk("R1 ot after reset", int'(ot_fault), 0);

    // R2 / R3 / R4: temperature sweep across knee and fold-back
    for (int t = 150; t <= 174; t++) begin
      int e;
      e = exp_thr(t);
      temp = 8'(t);
      cur = 14'(e - 1);
      step();
      chk(t <= 160 ? "R2 below limit" : "R3 below limit", int'(force_off), 0);
      cur = 14'(e);
      step();
      chk(t <= 160 ? "R2 at limit" : "R3 at limit", int'(force_off), 1);
      cur = '0;
      count_high(n);
      chk("R4 off-time cycles", n, OFF_CYC);
      chk("R4 released", int'(force_off), 0);
    end
    chk("R3 fold value 167C", exp_thr(167), 4634);

    // R5: hold current at limit through the off-time
    temp = 8'd100; cur = 14'd7000;
    step();
    chk("R5 start", int'(force_off), 1);
    count_high(n);
    chk("R5 not extended", n, OFF_CYC);
    chk("R5 low gap", int'(force_off), 0);
    step();
    chk("R5 restart after gap", int'(force_off), 1);
    cur = '0;
    count_high(n);

    // R8: side thresholds and single pulse
    hs_sel = 1'b0; cur = 14'd7999; step();
    chk("R8 ls below", int'(short_p), 0);
    cur = 14'd8000; step();
    chk("R8 ls at", int'(short_p), 1);
    step();
    chk("R8 single pulse", int'(short_p), 0);
    cur = '0; step();
    hs_sel = 1'b1; cur = 14'd10999; step();
    chk("R8 hs below", int'(short_p), 0);
    cur = 14'd11000; step();
    chk("R8 hs at", int'(short_p), 1);
    cur = '0; step();
    repeat (2100) step();

    // R9: blanking length
    cur = 14'd11000; edge_s = 1'b1; step();
    edge_s = 1'b0;
    i = 1;
    while (short_p !== 1'b1 && i < 3000) begin step(); i++; end
    chk("R9 blank length", i, BLANK_CYC + 1);

    // R9: restart of window by a second strobe
    cur = '0; step();
    cur = 14'd11000; edge_s = 1'b1; step();
    edge_s = 1'b0;
    seen = 0;
    repeat (800) begin step(); if (short_p === 1'b1) seen++; end
    chk("R9 masked before restart", seen, 0);
    edge_s = 1'b1; step();
    edge_s = 1'b0;
    i = 1;
    while (short_p !== 1'b1 && i < 3000) begin step(); i++; end
    chk("R9 restarted window", i, BLANK_CYC + 1);
    cur = '0;
    repeat (2100) step();

    // R6 / R7: overtemperature and hysteresis
    hs_sel = 1'b0;
    temp = 8'd175; cur = 14'd3000; step();
    chk("R6 ot set", int'(ot_fault), 1);
    chk("R6 no limit at 175", int'(force_off), 0);
    temp = 8'd170; cur = 14'd7000; step();
    chk("R6 no limit while ot", int'(force_off), 0);
    chk("R7 ot held 170", int'(ot_fault), 1);
    temp = 8'd166; cur = '0; step();
    chk("R7 ot held 166", int'(ot_fault), 1);
    temp = 8'd165; step();
    chk("R7 ot cleared 165", int'(ot_fault), 0);
    cur = 14'd7000; step();
    chk("R7 limiting resumes", int'(force_off), 1);
    cur = '0;

    finish_run();
  end
endmodule